// File: doc/BRIEF.md
# Branch Squash and Delay-Slot Controller

This controller drives the fetch side of a five-stage pipeline whenever a conditional branch is decoded. Every cycle it tells the fetch unit whether the next PC is the branch target or the sequential address. It says whether the PC and the instruction in fetch must be held. It also says whether the instruction now in fetch must be dropped, so that a no-op (all-zero opcode) is written into the IF/ID register at the end of the cycle. Target addresses and operands are computed elsewhere.

One of four schemes is chosen at build time by a parameter:
- **Stall:** fetch is held until the branch resolves in MEM.
- **Predict-not-taken:** sequential fetch goes on, and a taken branch squashes the one wrong-path instruction.
- **Delayed branch:** the instruction after the branch always completes.
- **Cancelling delayed branch:** a predicted-direction bit in the branch word annuls the slot instruction when the guess turns out wrong.

For the three speculative schemes the outcome is resolved in the branch's ID cycle. For the stall scheme it is resolved `STALL_DEPTH` cycles later, which is MEM with the default of 2.

The controller is a three-state machine:
- **ST_IDLE:** no branch is in flight.
- **ST_HOLD:** the stall scheme is waiting for the outcome.
- **ST_SLOT:** the delay-slot instruction is in ID.

Transitions:
- **IDLE→HOLD:** a branch in the stall scheme.
- **HOLD→HOLD:** the hold counter is not yet at zero.
- **HOLD→IDLE:** the resolution cycle.
- **IDLE→SLOT:** a branch in the delayed scheme, or a correctly predicted cancelling branch.
- **SLOT→IDLE:** always, after one cycle.
- **IDLE→IDLE:** a cycle with no branch, any predict-not-taken branch, or a mispredicted cancelling branch, whose slot is already annulled.

Top module: `branch_squash_ctrl`

## Requirements
- R1: After reset the controller is in ST_IDLE. With `id_branch` low, all four outputs are 0 (`pc_sel_target` = 0 means sequential PC, 1 means target PC).
- R2: Stall scheme: `ifid_flush` is 1 in the branch's ID cycle and in each of the following `STALL_DEPTH` cycles, so every branch costs `STALL_DEPTH`+1 bubbles (3 by default). `fetch_stall` is 1 in all of those cycles except a final cycle whose outcome is taken. In that cycle `pc_sel_target` is 1.
- R3: Stall scheme: `res_taken` is read only in the last hold cycle. `id_branch` is ignored while holding.
- R4: Predict-not-taken: a taken branch gives `pc_sel_target` = 1 and `ifid_flush` = 1 in its ID cycle. An untaken branch changes no output and costs no cycle.
- R5: Delayed scheme: `pc_sel_target` equals `res_taken` in the branch's ID cycle. `ifid_flush` is never raised, so the slot instruction always completes.
- R6: Cancelling scheme: `pc_sel_target` equals `res_taken` in the branch's ID cycle. `ifid_flush` is 1 exactly when `res_taken` differs from `id_pred`.
- R7: Delayed and cancelling schemes: in the cycle after a branch whose slot was not annulled, `id_branch` = 1 raises `slot_illegal`. That branch is not executed: there is no redirect, flush or stall, and the following cycle is back in ST_IDLE.
- R8: `id_pred` has no effect on any output in the stall, predict-not-taken and delayed schemes.
- R9: `fetch_stall` is raised only in the stall scheme, and never without `ifid_flush`.
- R10: Cancelling scheme: after a mispredicted branch, the next cycle is not a slot cycle. A branch there is handled as a new branch, not flagged illegal.
- R11: `slot_illegal` is never raised in the stall and predict-not-taken schemes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_branch | input | 1 | A conditional branch is decoded in ID this cycle |
| id_pred | input | 1 | Predicted-direction bit of the branch in ID (1 = taken) |
| res_taken | input | 1 | Branch outcome, valid in the resolving cycle (1 = taken) |
| pc_sel_target | output | 1 | 1 selects the branch target as next PC, 0 the sequential PC |
| fetch_stall | output | 1 | Hold the PC and the instruction in fetch |
| ifid_flush | output | 1 | Write a no-op into IF/ID at the end of this cycle |
| slot_illegal | output | 1 | A branch was found in a delay slot |

## Verification
Each corner case below is paired with what a faulty design would show at the ports:
- **Stall bubble count:** a design that counts the hold window off by one shows two or four flush cycles instead of three.
- **Outcome sampling point:** one that samples the outcome in the wrong hold cycle redirects on stale data.
- **Branch during a hold:** one that accepts a branch during a hold restarts the window.
- **Cancelling prediction/outcome pairs:** all four are driven. A design with an inverted compare annuls correct slots and keeps wrong ones.
- **Back-to-back branches:** in a slot they must raise the illegal flag without redirecting. After an annulled slot they must be taken as a new branch. A design that leaves the slot state wrong either misses the flag or flags a legal branch.
- **Prediction bit in the other schemes:** it is toggled randomly, so any leak of it into those schemes shows up as a miscompare.

// File: rtl/bsq_pkg.sv
`timescale 1ns/1ps
package bsq_pkg;

    // Branch handling scheme, fixed at build time
    typedef enum logic [1:0] {
        SCH_STALL     = 2'd0,
        SCH_NOT_TAKEN = 2'd1,
        SCH_DELAYED   = 2'd2,
        SCH_CANCEL    = 2'd3
    } scheme_e;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_SLOT = 2'd2
    } state_e;

    // Fetch-side control bundle
    typedef struct packed {
        logic pc_sel_target;
        logic fetch_stall;
        logic ifid_flush;
        logic slot_illegal;
    } fetch_ctl_t;

endpackage

// File: rtl/bsq_hold_timer.sv
`timescale 1ns/1ps
// Counts the cycles a stalled branch spends between ID and its resolving stage.
module bsq_hold_timer #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic last
);
    localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] START = CW'(DEPTH - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= START;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/bsq_next_state.sv
`timescale 1ns/1ps
// Transition logic of the controller.
module bsq_next_state
    import bsq_pkg::*;
#(
    parameter scheme_e SCHEME = SCH_CANCEL
) (
    input  state_e state,
    input  logic   id_branch,
    input  logic   id_pred,
    input  logic   res_taken,
    input  logic   hold_last,
    output state_e state_nx
);
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                if (id_branch) begin
                    unique case (SCHEME)
                        SCH_STALL:     state_nx = ST_HOLD;
                        SCH_NOT_TAKEN: state_nx = ST_IDLE;
                        SCH_DELAYED:   state_nx = ST_SLOT;
                        SCH_CANCEL:    state_nx = (res_taken != id_pred) ? ST_IDLE : ST_SLOT;
                        default:       state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_HOLD: state_nx = hold_last ? ST_IDLE : ST_HOLD;
            ST_SLOT: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bsq_out_decode.sv
`timescale 1ns/1ps
// Output logic of the controller.
module bsq_out_decode
    import bsq_pkg::*;
#(
    parameter scheme_e SCHEME = SCH_CANCEL
) (
    input  state_e     state,
    input  logic       id_branch,
    input  logic       id_pred,
    input  logic       res_taken,
    input  logic       hold_last,
    output fetch_ctl_t ctl
);
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_IDLE: begin
                if (id_branch) begin
                    unique case (SCHEME)
                        SCH_STALL: begin
                            // bubble into ID, keep the successor waiting in fetch
                            ctl.fetch_stall = 1'b1;
                            ctl.ifid_flush  = 1'b1;
                        end
                        SCH_NOT_TAKEN: begin
                            ctl.pc_sel_target = res_taken;
                            ctl.ifid_flush    = res_taken;
                        end
                        SCH_DELAYED: begin
                            ctl.pc_sel_target = res_taken;
                        end
                        SCH_CANCEL: begin
                            ctl.pc_sel_target = res_taken;
                            ctl.ifid_flush    = (res_taken != id_pred);
                        end
                        default: ctl = '0;
                    endcase
                end
            end
            ST_HOLD: begin
                ctl.ifid_flush = 1'b1;
                if (hold_last) begin
                    ctl.pc_sel_target = res_taken;
                    ctl.fetch_stall   = !res_taken;
                end else begin
                    ctl.fetch_stall   = 1'b1;
                end
            end
            ST_SLOT: begin
                ctl.slot_illegal = id_branch;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/branch_squash_ctrl.sv
`timescale 1ns/1ps
// Fetch-side branch controller: stall, predict-not-taken, delayed, cancelling.
module branch_squash_ctrl #(
    parameter bsq_pkg::scheme_e SCHEME      = bsq_pkg::SCH_CANCEL,
    parameter int unsigned      STALL_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic id_branch,
    input  logic id_pred,
    input  logic res_taken,
    output logic pc_sel_target,
    output logic fetch_stall,
    output logic ifid_flush,
    output logic slot_illegal
);
    import bsq_pkg::*;

    localparam bit USE_HOLD = (SCHEME == SCH_STALL);

    state_e     state_q;
    state_e     state_nx;
    logic       hold_last;
    fetch_ctl_t ctl;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    generate
        if (USE_HOLD) begin : g_hold
            logic hold_load;
            assign hold_load = (state_q == ST_IDLE) && id_branch;
            bsq_hold_timer #(
                .DEPTH (STALL_DEPTH)
            ) u_timer (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (hold_load),
                .tick  (state_q == ST_HOLD),
                .last  (hold_last)
            );
        end else begin : g_nohold
            assign hold_last = 1'b1;
        end
    endgenerate

    bsq_next_state #(
        .SCHEME (SCHEME)
    ) u_next (
        .state     (state_q),
        .id_branch (id_branch),
        .id_pred   (id_pred),
        .res_taken (res_taken),
        .hold_last (hold_last),
        .state_nx  (state_nx)
    );

    bsq_out_decode #(
        .SCHEME (SCHEME)
    ) u_out (
        .state     (state_q),
        .id_branch (id_branch),
        .id_pred   (id_pred),
        .res_taken (res_taken),
        .hold_last (hold_last),
        .ctl       (ctl)
    );

    assign pc_sel_target = ctl.pc_sel_target;
    assign fetch_stall   = ctl.fetch_stall;
    assign ifid_flush    = ctl.ifid_flush;
    assign slot_illegal  = ctl.slot_illegal;

endmodule

// File: rtl/bsq_checker.sv
`timescale 1ns/1ps
// Port-level properties of branch_squash_ctrl.
module bsq_checker
    import bsq_pkg::*;
#(
    parameter scheme_e     SCHEME      = SCH_CANCEL,
    parameter int unsigned STALL_DEPTH = 2
) (
    input logic clk,
    input logic rst_n,
    input logic id_branch,
    input logic id_pred,
    input logic res_taken,
    input logic pc_sel_target,
    input logic fetch_stall,
    input logic ifid_flush,
    input logic slot_illegal
);
    localparam bit IS_SLOTTED = (SCHEME == SCH_DELAYED) || (SCHEME == SCH_CANCEL);

    // R9: a held fetch always comes with a bubble
    a_r9_stall_needs_flush: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> ifid_flush);

    // R9: no fetch hold outside the stall scheme
    a_r9_no_stall_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (SCHEME != SCH_STALL) |-> !fetch_stall);

    // R2: a redirect never coincides with a held PC
    a_r2_redirect_releases: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_target |-> !fetch_stall);

    // R4: predict-not-taken squashes exactly on a taken branch
    a_r4_notaken_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (SCHEME == SCH_NOT_TAKEN) |-> ((ifid_flush == (id_branch && res_taken))
                                       && (pc_sel_target == ifid_flush)));

    // R5: delayed scheme never drops the slot
    a_r5_delayed_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (SCHEME == SCH_DELAYED) |-> !ifid_flush);

    // R6: a wrong prediction annuls the slot
    a_r6_cancel_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        ((SCHEME == SCH_CANCEL) && id_branch && !slot_illegal && (res_taken != id_pred))
        |-> ifid_flush);

    // R7: a branch right behind a kept slot is flagged
    a_r7_slot_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_SLOTTED && id_branch && !slot_illegal && !ifid_flush)
        |=> (slot_illegal == id_branch));

    // R7: a flagged branch does nothing else
    a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        slot_illegal |-> (!pc_sel_target && !ifid_flush && !fetch_stall));

    // R11: no slot flag in schemes without a slot
    a_r11_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_SLOTTED |-> !slot_illegal);

endmodule

bind branch_squash_ctrl bsq_checker #(
    .SCHEME      (SCHEME),
    .STALL_DEPTH (STALL_DEPTH)
) u_bsq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .id_branch     (id_branch),
    .id_pred       (id_pred),
    .res_taken     (res_taken),
    .pc_sel_target (pc_sel_target),
    .fetch_stall   (fetch_stall),
    .ifid_flush    (ifid_flush),
    .slot_illegal  (slot_illegal)
);

// File: tb/tb_branch_squash_ctrl.sv
`timescale 1ns/1ps
module tb_branch_squash_ctrl;
    import bsq_pkg::*;

    localparam int unsigned DEPTH = 2;
    localparam int NMODE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_branch = 1'b0;
    logic id_pred = 1'b0;
    logic res_taken = 1'b0;

    always #2 clk = ~clk;

    // observed {pc_sel_target, fetch_stall, ifid_flush, slot_illegal} per scheme
    logic [3:0] obs [NMODE];

    for (genvar g = 0; g < NMODE; g++) begin : g_mode
        logic pc_o, st_o, fl_o, il_o;
        branch_squash_ctrl #(
            .SCHEME      (scheme_e'(g)),
            .STALL_DEPTH (DEPTH)
        ) dut (
            .clk           (clk),
            .rst_n         (rst_n),
            .id_branch     (id_branch),
            .id_pred       (id_pred),
            .res_taken     (res_taken),
            .pc_sel_target (pc_o),
            .fetch_stall   (st_o),
            .ifid_flush    (fl_o),
            .slot_illegal  (il_o)
        );
        assign obs[g] = {pc_o, st_o, fl_o, il_o};
    end

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference state per scheme: 0 idle, 1 hold, 2 slot
    int ref_st [NMODE];
    int ref_cnt [NMODE];

    task automatic expect_of(input int m, input logic br, pr, tk,
                             output logic [3:0] ex, output int nst, output int ncnt);
        ex = 4'b0000;
        nst = 0;
        ncnt = ref_cnt[m];
        case (ref_st[m])
            0: if (br) begin
                case (m)
                    0: begin ex = 4'b0110; nst = 1; ncnt = DEPTH - 1; end
                    1: begin ex = {tk, 1'b0, tk, 1'b0}; end
                    2: begin ex = {tk, 3'b000}; nst = 2; end
                    default: begin
                        ex = {tk, 1'b0, (tk != pr), 1'b0};
                        nst = (tk != pr) ? 0 : 2;
                    end
                endcase
            end
            1: begin
                if (ref_cnt[m] == 0) begin
                    ex = {tk, !tk, 1'b1, 1'b0};
                    nst = 0;
                end else begin
                    ex = 4'b0110;
                    nst = 1;
                    ncnt = ref_cnt[m] - 1;
                end
            end
            default: begin
                ex = {3'b000, br};
                nst = 0;
            end
        endcase
    endtask

    function automatic string tag_of(input int m, input int st, input logic br);
        if (st == 2) return "R7";
        if (m == 0) return (st == 1) ? "R3/R9" : (br ? "R2/R8" : "R1");
        if (!br) return "R1";
        case (m)
            1: return "R4/R8/R11";
            2: return "R5/R8";
            default: return "R6/R10";
        endcase
    endfunction

    // apply one cycle of inputs, compare all schemes, advance the reference
    task automatic step(input logic br, input logic pr, input logic tk);
        int nst [NMODE];
        int ncnt [NMODE];
        @(negedge clk);
        id_branch = br;
        id_pred   = pr;
        res_taken = tk;
        #1;
        for (int m = 0; m < NMODE; m++) begin
            logic [3:0] ex;
            expect_of(m, br, pr, tk, ex, nst[m], ncnt[m]);
            checks++;
            if (obs[m] !== ex) begin
                fails++;
                $display("FAIL %s scheme %0d: outputs %b expected %b", tag_of(m, ref_st[m], br), m, obs[m], ex);
            end
        end
        for (int m = 0; m < NMODE; m++) begin
            ref_st[m]  = nst[m];
            ref_cnt[m] = ncnt[m];
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int fl_cnt;
        int seed;
        for (int m = 0; m < NMODE; m++) begin
            ref_st[m] = 0;
            ref_cnt[m] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, idle outputs
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0);

        // R2: stall scheme costs DEPTH+1 bubbles on a taken branch
        fl_cnt = 0;
        step(1'b1, 1'b0, 1'b0); fl_cnt += obs[0][1];
        step(1'b0, 1'b0, 1'b0); fl_cnt += obs[0][1];
        step(1'b0, 1'b0, 1'b1); fl_cnt += obs[0][1];
        step(1'b0, 1'b0, 1'b0); fl_cnt += obs[0][1];
        checks++;
        if (fl_cnt != DEPTH + 1) begin
            fails++;
            $display("FAIL R2 taken bubble count: actual %0d expected %0d", fl_cnt, DEPTH + 1);
        end

        // R3: untaken, with a branch arriving during the hold
        fl_cnt = 0;
        step(1'b1, 1'b1, 1'b1); fl_cnt += obs[0][1];
        step(1'b1, 1'b1, 1'b1); fl_cnt += obs[0][1];
        step(1'b0, 1'b1, 1'b0); fl_cnt += obs[0][1];
        step(1'b0, 1'b0, 1'b0); fl_cnt += obs[0][1];
        checks++;
        if (fl_cnt != DEPTH + 1) begin
            fails++;
            $display("FAIL R3 untaken bubble count: actual %0d expected %0d", fl_cnt, DEPTH + 1);
        end

        // R6: all four prediction/outcome pairs, each followed by quiet cycles
        for (int k = 0; k < 4; k++) begin
            step(1'b1, k[1], k[0]);
            step(1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
        end

        // R7: branch in a kept slot, then a legal branch after it
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        repeat (3) step(1'b0, 1'b0, 1'b0);

        // R10: mispredicted cancelling branch followed at once by a branch
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        repeat (3) step(1'b0, 1'b0, 1'b0);

        // R4/R5/R8: prediction bit flipped against the same outcome
        step(1'b1, 1'b0, 1'b0);
        repeat (3) step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        repeat (3) step(1'b0, 1'b0, 1'b0);

        // constrained random traffic with a fixed seed
        seed = 32'h5eed_b5c1;
        void'($urandom(seed));
        for (int i = 0; i < 3000; i++) begin
            logic br, pr, tk;
            br = ($urandom_range(0, 9) < 4);
            pr = $urandom_range(0, 1);
            tk = $urandom_range(0, 1);
            step(br, pr, tk);
        end

        done = 1'b1;
        finish_run();
    end

endmodule